// File: doc/BRIEF.md
# DMA Source-Chain Tag Sequencer

This block is the address sequencer of a DMA source channel that runs in chain mode. The memory holds a linked list of 16-byte tags. Each tag describes one data packet and says where the next tag is. A fetch unit outside this block reads each tag and presents three things for one cycle on a valid strobe: the 3-bit tag kind, the quadword count, and the tag's address field. That address field is already the value placed in the memory-address register. The block keeps the tag-address register (TADR) and returns the memory address to move data from (MADR). It also returns the next TADR and a flag that says the chain stops after this packet. All three results appear one cycle after the strobe.

Two of the tag kinds are subroutine-style. CALL pushes the address just past its own packet onto a two-entry return stack and jumps to the tag's address field. RET pops from that stack. A push onto a full stack ends the chain. A pop from an empty stack also ends the chain. A parameter removes the stack for channels that have none. On such a channel CALL and RET change no address and let the chain continue. A load strobe sets the starting TADR and empties the stack. All addresses are byte addresses. A packet of Q quadwords is Q·16 bytes long.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, res_vld and res_end are 0, and res_madr and res_tadr are 0.
- R2: When start_ld is high at a clock edge, TADR takes start_tadr and the return stack becomes empty. A tag_vld in the same cycle is ignored, so res_vld is low in the next cycle.
- R3: An accepted tag (tag_vld high, start_ld low) gives res_vld high for exactly the next cycle. Between results, res_madr, res_tadr and res_end hold their values.
- R4: Kind code 1 (count) sets MADR = TADR+16 and TADR = MADR_new + Q·16. The chain continues.
- R5: Kind code 2 (next) sets MADR = TADR+16 and TADR = tag_addr. The chain continues.
- R6: Kind codes 3 and 4 (reference, reference with stall) set MADR = tag_addr and TADR = TADR+16, and the chain continues. Kind code 0 (reference-end) sets MADR = tag_addr, leaves TADR unchanged and ends the chain.
- R7: Kind code 5 (call) sets MADR = TADR+16. With fewer than two stacked entries it pushes MADR_new + Q·16, sets TADR = tag_addr and continues. With two entries it ends the chain, leaves TADR and the stack unchanged, and the stack pointer never exceeds 2.
- R8: Kind code 6 (return) sets MADR = TADR+16. With a non-empty stack it pops the most recent entry into TADR, last in first out, and continues. With an empty stack it ends the chain and leaves TADR unchanged.
- R9: Kind code 7 (end) sets MADR = TADR+16, leaves TADR unchanged and ends the chain.
- R10: With HAS_STACK = 0, kind codes 5 and 6 set MADR = tag_addr, leave TADR unchanged and continue the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_ld | input | 1 | Load starting tag address, empty the stack |
| start_tadr | input | ADDR_W | Starting tag address |
| tag_vld | input | 1 | Tag fields valid this cycle |
| tag_kind | input | 3 | Tag kind code (0..7) |
| tag_qwc | input | QWC_W | Packet length in quadwords |
| tag_addr | input | ADDR_W | Tag address field, as placed in MADR |
| res_vld | output | 1 | Result valid (one cycle after an accepted tag) |
| res_end | output | 1 | Chain ends after this packet |
| res_madr | output | ADDR_W | Memory address for the packet |
| res_tadr | output | ADDR_W | Address of the next tag |

## Verification
The hardest conditions to reach are the stack limits. An overflow needs three calls with no return between them. A clean underflow needs a return when every earlier call has already been unwound, or a return right after a reload has emptied the stack. The stimulus starts with a fixed call-call-call-return-return-return run. It then feeds a long pseudo-random stream of tag kinds with periodic reloads, so full and empty stacks occur many times. A bench model of TADR, the pointer and both slots predicts every result for a stacked and an unstacked instance at once.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   typedef enum logic [2:0] {
      TK_REFE = 3'd0,
      TK_CNT  = 3'd1,
      TK_NEXT = 3'd2,
      TK_REF  = 3'd3,
      TK_REFS = 3'd4,
      TK_CALL = 3'd5,
      TK_RET  = 3'd6,
      TK_END  = 3'd7
   } tag_kind_e;

   localparam int unsigned TAG_BYTES = 16;
   localparam int unsigned QW_SHIFT  = 4;
endpackage

// File: rtl/dma_chain_stack.sv
module dma_chain_stack #(
   parameter int ADDR_W    = 32,
   parameter bit HAS_STACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_addr,
   output logic [1:0]        sp,
   output logic              can_push,
   output logic              can_pop,
   output logic [ADDR_W-1:0] top_addr
);
   generate
      if (HAS_STACK) begin : g_stack
         logic [1:0]        sp_q;
         logic [ADDR_W-1:0] slot0_q;
         logic [ADDR_W-1:0] slot1_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sp_q    <= 2'd0;
               slot0_q <= '0;
               slot1_q <= '0;
            end else if (clr) begin
               sp_q    <= 2'd0;
               slot0_q <= '0;
               slot1_q <= '0;
            end else if (push) begin
               case (sp_q)
                  2'd0: begin slot0_q <= push_addr; sp_q <= 2'd1; end
                  2'd1: begin slot1_q <= push_addr; sp_q <= 2'd2; end
                  default: ;
               endcase
            end else if (pop) begin
               case (sp_q)
                  2'd2: begin slot1_q <= '0; sp_q <= 2'd1; end
                  2'd1: begin slot0_q <= '0; sp_q <= 2'd0; end
                  default: ;
               endcase
            end
         end

         assign sp       = sp_q;
         assign can_push = (sp_q < 2'd2);
         assign can_pop  = (sp_q == 2'd1) || (sp_q == 2'd2);
         assign top_addr = (sp_q == 2'd2) ? slot1_q : slot0_q;
      end else begin : g_none
         assign sp       = 2'd0;
         assign can_push = 1'b0;
         assign can_pop  = 1'b0;
         assign top_addr = '0;
      end
   endgenerate
endmodule

// File: rtl/dma_chain_addr.sv
module dma_chain_addr
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int QWC_W     = 16,
   parameter bit HAS_STACK = 1'b1
) (
   input  tag_kind_e         kind,
   input  logic [QWC_W-1:0]  qwc,
   input  logic [ADDR_W-1:0] madr_in,
   input  logic [ADDR_W-1:0] tadr_cur,
   input  logic [ADDR_W-1:0] stk_top,
   input  logic              can_push,
   input  logic              can_pop,
   output logic [ADDR_W-1:0] madr_nx,
   output logic [ADDR_W-1:0] tadr_nx,
   output logic [ADDR_W-1:0] push_addr,
   output logic              end_nx,
   output logic              push_req,
   output logic              pop_req
);
   localparam int PKT_W = QWC_W + int'(QW_SHIFT);

   logic [PKT_W-1:0]  pkt_bytes;
   logic [ADDR_W-1:0] pkt;
   logic [ADDR_W-1:0] body;

   assign pkt_bytes = {qwc, {QW_SHIFT{1'b0}}};
   assign pkt       = ADDR_W'(pkt_bytes);
   assign body      = tadr_cur + ADDR_W'(TAG_BYTES);
   assign push_addr = body + pkt;

   always_comb begin
      madr_nx  = madr_in;
      tadr_nx  = tadr_cur;
      end_nx   = 1'b0;
      push_req = 1'b0;
      pop_req  = 1'b0;
      case (kind)
         TK_REFE: end_nx = 1'b1;
         TK_CNT: begin
            madr_nx = body;
            tadr_nx = body + pkt;
         end
         TK_NEXT: begin
            madr_nx = body;
            tadr_nx = madr_in;
         end
         TK_REF, TK_REFS: tadr_nx = body;
         TK_CALL: begin
            if (HAS_STACK) begin
               madr_nx = body;
               if (can_push) begin
                  push_req = 1'b1;
                  tadr_nx  = madr_in;
               end else begin
                  end_nx = 1'b1;
               end
            end
         end
         TK_RET: begin
            if (HAS_STACK) begin
               madr_nx = body;
               if (can_pop) begin
                  pop_req = 1'b1;
                  tadr_nx = stk_top;
               end else begin
                  end_nx = 1'b1;
               end
            end
         end
         TK_END: begin
            madr_nx = body;
            end_nx  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int QWC_W     = 16,
   parameter bit HAS_STACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ld,
   input  logic [ADDR_W-1:0] start_tadr,
   input  logic              tag_vld,
   input  logic [2:0]        tag_kind,
   input  logic [QWC_W-1:0]  tag_qwc,
   input  logic [ADDR_W-1:0] tag_addr,
   output logic              res_vld,
   output logic              res_end,
   output logic [ADDR_W-1:0] res_madr,
   output logic [ADDR_W-1:0] res_tadr
);
   localparam int MIN_ADDR_W = QWC_W + int'(QW_SHIFT) + 1;

   initial begin
      if (ADDR_W < MIN_ADDR_W)
         $error("dma_chain_seq: ADDR_W must be at least QWC_W+5");
      if (QWC_W < 1)
         $error("dma_chain_seq: QWC_W must be positive");
   end

   logic              accept;
   logic [ADDR_W-1:0] tadr_q;
   logic [ADDR_W-1:0] madr_q;
   logic              vld_q;
   logic              end_q;

   logic [ADDR_W-1:0] madr_nx;
   logic [ADDR_W-1:0] tadr_nx;
   logic [ADDR_W-1:0] push_addr;
   logic              end_nx;
   logic              push_req;
   logic              pop_req;
   logic [1:0]        stk_ptr;
   logic              can_push;
   logic              can_pop;
   logic [ADDR_W-1:0] stk_top;

   assign accept = tag_vld & ~start_ld;

   dma_chain_addr #(
      .ADDR_W    (ADDR_W),
      .QWC_W     (QWC_W),
      .HAS_STACK (HAS_STACK)
   ) u_addr (
      .kind      (tag_kind_e'(tag_kind)),
      .qwc       (tag_qwc),
      .madr_in   (tag_addr),
      .tadr_cur  (tadr_q),
      .stk_top   (stk_top),
      .can_push  (can_push),
      .can_pop   (can_pop),
      .madr_nx   (madr_nx),
      .tadr_nx   (tadr_nx),
      .push_addr (push_addr),
      .end_nx    (end_nx),
      .push_req  (push_req),
      .pop_req   (pop_req)
   );

   dma_chain_stack #(
      .ADDR_W    (ADDR_W),
      .HAS_STACK (HAS_STACK)
   ) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_ld),
      .push      (accept & push_req),
      .pop       (accept & pop_req),
      .push_addr (push_addr),
      .sp        (stk_ptr),
      .can_push  (can_push),
      .can_pop   (can_pop),
      .top_addr  (stk_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tadr_q <= '0;
         madr_q <= '0;
         vld_q  <= 1'b0;
         end_q  <= 1'b0;
      end else begin
         vld_q <= accept;
         if (start_ld) begin
            tadr_q <= start_tadr;
         end else if (accept) begin
            tadr_q <= tadr_nx;
            madr_q <= madr_nx;
            end_q  <= end_nx;
         end
      end
   end

   assign res_vld  = vld_q;
   assign res_end  = end_q;
   assign res_madr = madr_q;
   assign res_tadr = tadr_q;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
   parameter int ADDR_W    = 32,
   parameter int QWC_W     = 16,
   parameter bit HAS_STACK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_ld,
   input logic [ADDR_W-1:0] start_tadr,
   input logic              tag_vld,
   input logic [2:0]        tag_kind,
   input logic [QWC_W-1:0]  tag_qwc,
   input logic [ADDR_W-1:0] tag_addr,
   input logic              res_vld,
   input logic              res_end,
   input logic [ADDR_W-1:0] res_madr,
   input logic [ADDR_W-1:0] res_tadr,
   input logic [1:0]        stk_ptr
);
   logic              acc;
   logic [ADDR_W-1:0] pkt_b;
   assign acc   = tag_vld & ~start_ld;
   assign pkt_b = ADDR_W'({tag_qwc, 4'h0});

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_ld |=> (res_tadr == $past(start_tadr)) && (stk_ptr == 2'd0) && !res_vld);

   a_r3_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> res_vld);

   a_r3_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !res_vld && $stable(res_madr) && $stable(res_end));

   a_r4_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && tag_kind == 3'd1) |=> !res_end
         && (res_madr == ADDR_W'($past(res_tadr) + ADDR_W'(16)))
         && (res_tadr == ADDR_W'(res_madr + $past(pkt_b))));

   a_r5_next: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && tag_kind == 3'd2) |=> !res_end && (res_tadr == $past(tag_addr)));

   a_r6_refe: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && tag_kind == 3'd0) |=> res_end && $stable(res_tadr)
         && (res_madr == $past(tag_addr)));

   a_r9_end: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && tag_kind == 3'd7) |=> res_end && $stable(res_tadr)
         && (res_madr == ADDR_W'($past(res_tadr) + ADDR_W'(16))));

   a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ptr != 2'd3);

   generate
      if (HAS_STACK) begin : g_stk_chk
         a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && tag_kind == 3'd5 && stk_ptr == 2'd2) |=> res_end && $stable(res_tadr)
               && (stk_ptr == 2'd2));
         a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && tag_kind == 3'd6 && stk_ptr == 2'd0) |=> res_end && $stable(res_tadr));
      end else begin : g_nostk_chk
         a_r10_passive: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && (tag_kind == 3'd5 || tag_kind == 3'd6)) |=> !res_end && $stable(res_tadr));
      end
   endgenerate
endmodule

bind dma_chain_seq dma_chain_seq_chk #(
   .ADDR_W    (ADDR_W),
   .QWC_W     (QWC_W),
   .HAS_STACK (HAS_STACK)
) u_chk (.*);

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb;
   localparam int AW = 16;
   localparam int QW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_ld = 1'b0;
   logic [AW-1:0] start_tadr = '0;
   logic          tag_vld = 1'b0;
   logic [2:0]    tag_kind = 3'd0;
   logic [QW-1:0] tag_qwc = '0;
   logic [AW-1:0] tag_addr = '0;

   logic          a_vld, a_end, b_vld, b_end;
   logic [AW-1:0] a_madr, a_tadr, b_madr, b_tadr;

   // model state: stacked instance (a) and unstacked instance (b)
   logic [AW-1:0] ma_tadr = '0, ma_madr = '0, ma_s0 = '0, ma_s1 = '0;
   logic          ma_end = 1'b0;
   int            ma_sp = 0;
   logic [AW-1:0] mb_tadr = '0, mb_madr = '0;
   logic          mb_end = 1'b0;

   int total = 0;
   int bad = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always #4 clk = ~clk;

   dma_chain_seq #(.ADDR_W(AW), .QWC_W(QW), .HAS_STACK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_ld(start_ld), .start_tadr(start_tadr),
      .tag_vld(tag_vld), .tag_kind(tag_kind), .tag_qwc(tag_qwc), .tag_addr(tag_addr),
      .res_vld(a_vld), .res_end(a_end), .res_madr(a_madr), .res_tadr(a_tadr));

   dma_chain_seq #(.ADDR_W(AW), .QWC_W(QW), .HAS_STACK(1'b0)) u_dut_ns (
      .clk(clk), .rst_n(rst_n), .start_ld(start_ld), .start_tadr(start_tadr),
      .tag_vld(tag_vld), .tag_kind(tag_kind), .tag_qwc(tag_qwc), .tag_addr(tag_addr),
      .res_vld(b_vld), .res_end(b_end), .res_madr(b_madr), .res_tadr(b_tadr));

   task automatic chk(input string req, input string who,
                      input logic gv, input logic ge, input logic [AW-1:0] gm, input logic [AW-1:0] gt,
                      input logic ev, input logic ee, input logic [AW-1:0] em, input logic [AW-1:0] et);
      total++;
      if (gv !== ev || ge !== ee || gm !== em || gt !== et) begin
         bad++;
         $display("FAIL %s %s: got vld=%b end=%b madr=%h tadr=%h exp vld=%b end=%b madr=%h tadr=%h",
                  req, who, gv, ge, gm, gt, ev, ee, em, et);
      end
   endtask

   function automatic string rq(input int k, input bit stk);
      if (!stk && (k == 5 || k == 6)) return "R10";
      case (k)
         1: return "R4";
         2: return "R5";
         5: return "R7";
         6: return "R8";
         7: return "R9";
         default: return "R6";
      endcase
   endfunction

   // called at a negedge with inputs idle; returns at a negedge
   task automatic run_tag(input int k, input logic [QW-1:0] q, input logic [AW-1:0] adr);
      logic [AW-1:0] body, pkt;
      // stacked model (R4..R9)
      body = ma_tadr + AW'(16);
      pkt  = AW'({q, 4'h0});
      ma_end = 1'b0;
      case (k)
         0: begin ma_madr = adr; ma_end = 1'b1; end
         1: begin ma_madr = body; ma_tadr = body + pkt; end
         2: begin ma_madr = body; ma_tadr = adr; end
         3, 4: begin ma_madr = adr; ma_tadr = body; end
         5: begin
            ma_madr = body;
            if (ma_sp == 0) begin ma_s0 = body + pkt; ma_sp = 1; ma_tadr = adr; end
            else if (ma_sp == 1) begin ma_s1 = body + pkt; ma_sp = 2; ma_tadr = adr; end
            else ma_end = 1'b1;
         end
         6: begin
            ma_madr = body;
            if (ma_sp == 2) begin ma_tadr = ma_s1; ma_s1 = '0; ma_sp = 1; end
            else if (ma_sp == 1) begin ma_tadr = ma_s0; ma_s0 = '0; ma_sp = 0; end
            else ma_end = 1'b1;
         end
         default: begin ma_madr = body; ma_end = 1'b1; end
      endcase
      // unstacked model (R10)
      body = mb_tadr + AW'(16);
      mb_end = 1'b0;
      case (k)
         0: begin mb_madr = adr; mb_end = 1'b1; end
         1: begin mb_madr = body; mb_tadr = body + pkt; end
         2: begin mb_madr = body; mb_tadr = adr; end
         3, 4: begin mb_madr = adr; mb_tadr = body; end
         5, 6: mb_madr = adr;
         default: begin mb_madr = body; mb_end = 1'b1; end
      endcase

      tag_vld = 1'b1; tag_kind = 3'(k); tag_qwc = q; tag_addr = adr;
      @(negedge clk);
      tag_vld = 1'b0; tag_kind = 3'(~k); tag_addr = ~adr;
      chk(rq(k, 1'b1), "stacked", a_vld, a_end, a_madr, a_tadr, 1'b1, ma_end, ma_madr, ma_tadr);
      chk(rq(k, 1'b0), "unstacked", b_vld, b_end, b_madr, b_tadr, 1'b1, mb_end, mb_madr, mb_tadr);
      @(negedge clk);
      // R3: outputs hold, valid drops
      chk("R3", "stacked", a_vld, a_end, a_madr, a_tadr, 1'b0, ma_end, ma_madr, ma_tadr);
      chk("R3", "unstacked", b_vld, b_end, b_madr, b_tadr, 1'b0, mb_end, mb_madr, mb_tadr);
   endtask

   // R2: load with a competing tag strobe that must be ignored
   task automatic load(input logic [AW-1:0] t);
      start_ld = 1'b1; start_tadr = t;
      tag_vld = 1'b1; tag_kind = 3'd1; tag_qwc = '1; tag_addr = 16'hBEEF;
      @(negedge clk);
      start_ld = 1'b0; tag_vld = 1'b0;
      ma_tadr = t; ma_sp = 0; ma_s0 = '0; ma_s1 = '0;
      mb_tadr = t;
      chk("R2", "stacked", a_vld, a_end, a_madr, a_tadr, 1'b0, ma_end, ma_madr, ma_tadr);
      chk("R2", "unstacked", b_vld, b_end, b_madr, b_tadr, 1'b0, mb_end, mb_madr, mb_tadr);
   endtask

   initial begin
      #(8 * 100000);
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "stacked", a_vld, a_end, a_madr, a_tadr, 1'b0, 1'b0, '0, '0);
      chk("R1", "unstacked", b_vld, b_end, b_madr, b_tadr, 1'b0, 1'b0, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep every kind against counts 0, 1, 7, 15
      load(16'h0100);
      for (int k = 0; k < 8; k++) begin
         for (int qi = 0; qi < 4; qi++) begin
            logic [QW-1:0] q;
            q = (qi == 0) ? 4'd0 : (qi == 1) ? 4'd1 : (qi == 2) ? 4'd7 : 4'd15;
            run_tag(k, q, AW'(16'h3000 + k * 16'h0040 + qi * 16'h0010));
         end
      end

      // R7/R8: nested calls to overflow, then unwind past empty
      load(16'h0800);
      run_tag(5, 4'd2, 16'h1000);
      run_tag(5, 4'd3, 16'h2000);
      run_tag(5, 4'd4, 16'h3000);
      run_tag(6, 4'd1, 16'h0000);
      run_tag(6, 4'd1, 16'h0000);
      run_tag(6, 4'd1, 16'h0000);
      // R2: reload empties a partly filled stack
      run_tag(5, 4'd5, 16'h4400);
      load(16'h0a00);
      run_tag(6, 4'd0, 16'h0000);

      // pseudo-random stream with periodic reloads
      for (int n = 0; n < 1500; n++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         if (n % 40 == 39) load({lcg[27:20], 8'h00});
         else run_tag(int'(lcg[18:16]), lcg[23:20], {lcg[31:24], lcg[11:8], 4'h0});
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule